// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synthesizable behavioural model of a flow-through synchronous burst SRAM with a small internal array. The default array is 64 words of 36 bits, split into four 9-bit byte lanes. On each rising clock edge it samples the address, the chip enables, the two address strobes, the advance input, the write controls and the write data. From these it starts a burst, continues a burst, or deselects the device.

A burst covers an aligned block of four words. Its start address comes from the address bus. The two low address bits then follow a linear or an interleaved order, chosen by a static mode input. Writes are applied per byte lane, and a global write overrides the lane controls. Read data is not held in an output register: the word at the registered address shows on the data output in the same cycle. An asynchronous active-low output enable gates the data output. A sleep input blocks all access.

High impedance is represented by the `q_en` output. When `q_en` is 0, `q` is driven to all zeros, and an external pad would tristate.

Top module: `burst_sram_ctl`

## Requirements
- R1: When `ads_proc_n`=0 and `ce_n`=0, with `ce_hi`=1 and `ce_lo_n`=0, the edge starts a read at `addr`. Write controls are ignored, and after the edge `q` shows the stored word at `addr`.
- R2: While `ce_n`=1, `ads_proc_n` is ignored. The edge is handled as if it were high, so an ongoing read burst continues at its current address.
- R3: When `ads_ctrl_n`=0 and all enables are asserted, the edge starts an access at `addr`. It is a write if any lane is enabled for writing (R6, R7); otherwise it is a read.
- R4: A strobe whose enables are not all asserted deselects the device. After that, `q_en`=0, and later cycles without a strobe neither write nor read.
- R5: When both strobes are low and all enables are asserted, the cycle is a read at `addr`, and the array is not written even if `wr_all_n`=0.
- R6: `wr_all_n`=0 writes all four lanes, whatever the values of `bw_gate_n` and `bw_n`.
- R7: `bw_n[i]`=0 writes lane i only while `bw_gate_n`=0. Lane i is bits [9i+8:9i]. When `bw_gate_n`=1 and `wr_all_n`=1, the access is a read.
- R8: In a cycle with no strobe and an active burst, `adv_n`=0 steps the burst counter and `adv_n`=1 holds it. The write controls choose a write or a read at the resulting address.
- R9: With `seq_ilv`=0, the burst order is linear: the low two address bits are (start + count) mod 4. The upper bits stay fixed, and count 4 wraps to the start.
- R10: With `seq_ilv`=1, the burst order is interleaved: the low two address bits are start XOR count.
- R11: Read data is flow-through. It is valid in the cycle that follows the sampling edge, including a read of a word written one edge earlier.
- R12: `q_en` is 1 only in a read cycle of a selected device with `oe_n`=0. It follows `oe_n` without waiting for a clock edge, and it is 0 in write cycles. While `q_en`=0, `q` is 0.
- R13: While `sleep`=1, `q_en` is 0 at once and no write reaches the array. After `sleep` returns to 0, a new strobe is needed before any access.
- R14: After reset, the device is deselected and `q_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Main chip enable, active low; gates `ads_proc_n` |
| ce_hi | input | 1 | Depth-expansion enable, active high |
| ce_lo_n | input | 1 | Depth-expansion enable, active low |
| ads_proc_n | input | 1 | Read-only address strobe, active low |
| ads_ctrl_n | input | 1 | Read/write/deselect address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | AW (6) | Word address |
| wr_all_n | input | 1 | Global write, active low |
| bw_gate_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES (4) | Per-lane write, active low |
| seq_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| wdata | input | LANES*LANE_W (36) | Write data |
| q | output | LANES*LANE_W (36) | Read data; 0 when not driven |
| q_en | output | 1 | Read data is driven (0 stands for high impedance) |

## Verification
Every sampled result is due exactly one edge after its stimulus. This covers a new burst address, a step of the burst, the data of a read, and the end of bus drive in a write or deselect cycle. The bench applies inputs on the falling edge, lets one rising edge pass, and checks on the next falling edge. The output enable and sleep act without a clock: the bench changes them in the low phase and checks one nanosecond later, before any edge. Array contents are checked by reads issued after the write under test, using a bench model that is updated only from the write rules.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic [2:0] {
      CMD_IDLE     = 3'd0,
      CMD_DESEL    = 3'd1,
      CMD_START_RD = 3'd2,
      CMD_START_WR = 3'd3,
      CMD_CONT_RD  = 3'd4,
      CMD_CONT_WR  = 3'd5,
      CMD_SLEEP    = 3'd6
   } sram_cmd_e;
endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
   import burst_sram_pkg::*;
(
   input  logic      ce_n,
   input  logic      ce_hi,
   input  logic      ce_lo_n,
   input  logic      ads_proc_n,
   input  logic      ads_ctrl_n,
   input  logic      sleep,
   input  logic      active,
   input  logic      wr_any,
   output sram_cmd_e cmd
);
   logic all_en;
   assign all_en = !ce_n && ce_hi && !ce_lo_n;

   always_comb begin
      if (sleep)
         cmd = CMD_SLEEP;
      else if (!ads_proc_n && !ce_n)
         cmd = all_en ? CMD_START_RD : CMD_DESEL;   // read-only strobe wins
      else if (!ads_ctrl_n)
         cmd = !all_en ? CMD_DESEL : (wr_any ? CMD_START_WR : CMD_START_RD);
      else if (active)
         cmd = wr_any ? CMD_CONT_WR : CMD_CONT_RD;
      else
         cmd = CMD_IDLE;
   end
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq #(
   parameter int BITS = 2
) (
   input  logic [BITS-1:0] start_lo,
   input  logic [BITS-1:0] count,
   input  logic            interleave,
   output logic [BITS-1:0] addr_lo
);
   if (BITS < 1) begin : g_bad_bits
      $error("burst_sram_seq: BITS must be at least 1");
   end

   logic [BITS-1:0] lin_lo;
   logic [BITS-1:0] ilv_lo;
   assign lin_lo  = start_lo + count;
   assign ilv_lo  = start_lo ^ count;
   assign addr_lo = interleave ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
   parameter int AW     = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        lane_we,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (DEPTH * LANES * LANE_W > 65536) begin : g_bad_size
      $error("burst_sram_array: array too large for a behavioural model");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (lane_we[l])
            mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      end
      assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
   import burst_sram_pkg::*;
#(
   parameter int AW         = 6,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_n,
   input  logic                    ce_hi,
   input  logic                    ce_lo_n,
   input  logic                    ads_proc_n,
   input  logic                    ads_ctrl_n,
   input  logic                    adv_n,
   input  logic [AW-1:0]           addr,
   input  logic                    wr_all_n,
   input  logic                    bw_gate_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    seq_ilv,
   input  logic                    oe_n,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] q,
   output logic                    q_en
);
   localparam int DW = LANES * LANE_W;

   if (AW <= BURST_BITS) begin : g_bad_aw
      $error("burst_sram_ctl: AW must exceed BURST_BITS");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram_ctl: lane geometry must be non-zero");
   end

   sram_cmd_e             cmd;
   logic [LANES-1:0]      lane_mask;
   logic [LANES-1:0]      arr_we;
   logic                  wr_any;
   logic                  is_start;
   logic                  is_wr;
   logic                  active_q;
   logic                  rd_q;
   logic [AW-1:0]         base_q;
   logic [AW-1:0]         base_n;
   logic [BURST_BITS-1:0] cnt_q;
   logic [BURST_BITS-1:0] cnt_n;
   logic [BURST_BITS-1:0] lo_n;
   logic [AW-1:0]         eff_n;
   logic [AW-1:0]         cur_q;
   logic [DW-1:0]         arr_rdata;

   // Lane write mask: global write overrides the gated per-lane controls.
   always_comb begin
      if (!wr_all_n)
         lane_mask = '1;
      else if (!bw_gate_n)
         lane_mask = ~bw_n;
      else
         lane_mask = '0;
   end
   assign wr_any = |lane_mask;

   burst_sram_decode u_decode (
      .ce_n       (ce_n),
      .ce_hi      (ce_hi),
      .ce_lo_n    (ce_lo_n),
      .ads_proc_n (ads_proc_n),
      .ads_ctrl_n (ads_ctrl_n),
      .sleep      (sleep),
      .active     (active_q),
      .wr_any     (wr_any),
      .cmd        (cmd)
   );

   assign is_start = (cmd == CMD_START_RD) || (cmd == CMD_START_WR);
   assign is_wr    = (cmd == CMD_START_WR) || (cmd == CMD_CONT_WR);
   assign base_n   = is_start ? addr : base_q;
   assign cnt_n    = is_start ? '0 : cnt_q + {{(BURST_BITS-1){1'b0}}, !adv_n};

   burst_sram_seq #(.BITS(BURST_BITS)) u_seq (
      .start_lo   (base_n[BURST_BITS-1:0]),
      .count      (cnt_n),
      .interleave (seq_ilv),
      .addr_lo    (lo_n)
   );
   assign eff_n  = {base_n[AW-1:BURST_BITS], lo_n};
   assign arr_we = is_wr ? lane_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
         cur_q    <= '0;
      end else begin
         case (cmd)
            CMD_START_RD, CMD_START_WR: begin
               active_q <= 1'b1;
               base_q   <= addr;
               cnt_q    <= cnt_n;
               cur_q    <= eff_n;
               rd_q     <= (cmd == CMD_START_RD);
            end
            CMD_CONT_RD, CMD_CONT_WR: begin
               cnt_q <= cnt_n;
               cur_q <= eff_n;
               rd_q  <= (cmd == CMD_CONT_RD);
            end
            CMD_DESEL, CMD_SLEEP: begin
               active_q <= 1'b0;
               rd_q     <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   burst_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .lane_we (arr_we),
      .waddr   (eff_n),
      .wdata   (wdata),
      .raddr   (cur_q),
      .rdata   (arr_rdata)
   );

   // Flow-through read: no output register between array and pins.
   assign q_en = active_q && rd_q && !oe_n && !sleep;
   assign q    = q_en ? arr_rdata : '0;

   AST_PROC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_proc_n && !ce_n && ce_hi && !ce_lo_n && !sleep) |=> (cur_q == $past(addr))); // R1
   AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_proc_n && !ads_ctrl_n && !ce_n && ce_hi && !ce_lo_n && !sleep) |-> (arr_we == '0)); // R5
   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_DESEL) |=> !q_en); // R4
   AST_ADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == CMD_CONT_RD || cmd == CMD_CONT_WR) && adv_n) |=> (cur_q == $past(cur_q))); // R8
   AST_WRITE_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |=> !q_en); // R12
   AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (arr_we == '0)); // R13
   AST_SLEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !active_q); // R13
endmodule

// File: tb/burst_sram_ctl_bench.sv
module burst_sram_ctl_bench;
   localparam int AW = 6;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_n, ce_hi, ce_lo_n, ads_proc_n, ads_ctrl_n, adv_n;
   logic [AW-1:0] addr;
   logic          wr_all_n, bw_gate_n;
   logic [3:0]    bw_n;
   logic          seq_ilv, oe_n, sleep;
   logic [DW-1:0] wdata;
   logic [DW-1:0] q;
   logic          q_en;

   int errors = 0;
   int checks = 0;
   logic [DW-1:0] mdl [64];

   always #4 clk = ~clk;

   burst_sram_ctl u_burst_sram_ctl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .addr(addr),
      .wr_all_n(wr_all_n), .bw_gate_n(bw_gate_n), .bw_n(bw_n), .seq_ilv(seq_ilv),
      .oe_n(oe_n), .sleep(sleep), .wdata(wdata), .q(q), .q_en(q_en)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_in;
      ce_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
      ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
      wr_all_n = 1'b1; bw_gate_n = 1'b1; bw_n = 4'hF;
      oe_n = 1'b0; sleep = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] d);
      idle_in;
      ads_ctrl_n = 1'b0; addr = a; wr_all_n = 1'b0; bw_gate_n = 1'b1; wdata = d;
      tick;
      chk("R12 bus off in write", {63'd0, q_en}, 64'd0);
      mdl[a] = d;
      idle_in;
   endtask

   task automatic rd_proc(input logic [AW-1:0] a, input string req);
      idle_in;
      ads_proc_n = 1'b0; addr = a;
      tick;
      chk(req, {63'd0, q_en}, 64'd1);
      chk(req, {28'd0, q}, {28'd0, mdl[a]});
      idle_in;
   endtask

   task automatic t_reset;
      chk("R14 reset q_en", {63'd0, q_en}, 64'd0);
      chk("R14 reset q", {28'd0, q}, 64'd0);
   endtask

   task automatic t_global_write;
      idle_in;
      ads_ctrl_n = 1'b0; addr = 6'd5; wr_all_n = 1'b0; bw_gate_n = 1'b1; bw_n = 4'hF;
      wdata = 36'h9_ABCD_1234;
      tick;
      chk("R12 write cycle bus off", {63'd0, q_en}, 64'd0);
      mdl[5] = 36'h9_ABCD_1234;
      rd_proc(6'd5, "R6 global write all lanes");
      wr_full(6'd33, 36'h3_3333_0033);
      rd_proc(6'd33, "R11 flow-through read after write");
   endtask

   task automatic t_byte_write;
      logic [DW-1:0] a_v, b_v, e_v;
      a_v = 36'h1_2345_6789;
      b_v = 36'hF_EDCB_A987;
      wr_full(6'd8, a_v);
      idle_in;
      ads_ctrl_n = 1'b0; addr = 6'd8; bw_gate_n = 1'b0; bw_n = 4'b1010; wdata = b_v;
      tick;
      e_v = {a_v[35:27], b_v[26:18], a_v[17:9], b_v[8:0]};
      mdl[8] = e_v;
      idle_in;
      ads_ctrl_n = 1'b0; addr = 6'd8; bw_gate_n = 1'b1; bw_n = 4'b0000; wdata = '1;
      tick;
      chk("R7 ungated lanes read q_en", {63'd0, q_en}, 64'd1);
      chk("R7 lane mask result", {28'd0, q}, {28'd0, e_v});
      chk("R3 strobe read", {28'd0, q}, {28'd0, mdl[8]});
      idle_in;
   endtask

   task automatic t_linear;
      for (int i = 0; i < 4; i++) wr_full(6'(16 + i), 36'hA_0000_0000 + 36'(i * 17 + 1));
      idle_in;
      ads_proc_n = 1'b0; addr = 6'd18;
      tick;
      chk("R9 linear start", {28'd0, q}, {28'd0, mdl[18]});
      idle_in;
      adv_n = 1'b0;
      tick; chk("R9 linear step1", {28'd0, q}, {28'd0, mdl[19]});
      tick; chk("R9 linear wrap", {28'd0, q}, {28'd0, mdl[16]});
      tick; chk("R9 linear step3", {28'd0, q}, {28'd0, mdl[17]});
      tick; chk("R9 linear back to start", {28'd0, q}, {28'd0, mdl[18]});
      adv_n = 1'b1;
      tick; chk("R8 advance high holds", {28'd0, q}, {28'd0, mdl[18]});
      idle_in;
   endtask

   task automatic t_interleave;
      idle_in;
      seq_ilv = 1'b1;
      ads_proc_n = 1'b0; addr = 6'd17;
      tick;
      chk("R10 ilv start", {28'd0, q}, {28'd0, mdl[17]});
      ads_proc_n = 1'b1; adv_n = 1'b0;
      tick; chk("R10 ilv step1", {28'd0, q}, {28'd0, mdl[16]});
      tick; chk("R10 ilv step2", {28'd0, q}, {28'd0, mdl[19]});
      tick; chk("R10 ilv step3", {28'd0, q}, {28'd0, mdl[18]});
      seq_ilv = 1'b0;
      idle_in;
   endtask

   task automatic t_burst_write;
      idle_in;
      ads_ctrl_n = 1'b0; addr = 6'd24; wr_all_n = 1'b0; wdata = 36'h2_4242_4242;
      tick;
      mdl[24] = 36'h2_4242_4242;
      ads_ctrl_n = 1'b1; adv_n = 1'b0; wdata = 36'h2_5555_5555;
      tick;
      chk("R8 continuation write bus off", {63'd0, q_en}, 64'd0);
      mdl[25] = 36'h2_5555_5555;
      wdata = 36'h2_6666_6666;
      tick;
      mdl[26] = 36'h2_6666_6666;
      idle_in;
      rd_proc(6'd24, "R3 write start");
      rd_proc(6'd25, "R8 continuation write step1");
      rd_proc(6'd26, "R8 continuation write step2");
   endtask

   task automatic t_priority;
      wr_full(6'd30, 36'h5_A5A5_A5A5);
      idle_in;
      ads_proc_n = 1'b0; ads_ctrl_n = 1'b0; addr = 6'd30; wr_all_n = 1'b0;
      wdata = 36'h0_5A5A_5A5A;
      tick;
      chk("R5 both strobes read q_en", {63'd0, q_en}, 64'd1);
      chk("R5 both strobes read data", {28'd0, q}, {28'd0, mdl[30]});
      idle_in;
      rd_proc(6'd30, "R5 no write took place");
      idle_in;
      ads_proc_n = 1'b0; addr = 6'd31; wr_all_n = 1'b0; wdata = 36'h0_DEAD_0000;
      tick;
      idle_in;
      wr_full(6'd31, 36'h3_1313_1313);
      rd_proc(6'd31, "R1 proc read after proc strobe");
   endtask

   task automatic t_enables;
      rd_proc(6'd16, "R1 proc read");
      ce_n = 1'b1; ads_proc_n = 1'b0; addr = 6'd40;
      tick;
      chk("R2 proc strobe ignored q_en", {63'd0, q_en}, 64'd1);
      chk("R2 proc strobe ignored data", {28'd0, q}, {28'd0, mdl[16]});
      idle_in;
      ce_n = 1'b1; ads_ctrl_n = 1'b0;
      tick;
      chk("R4 ctrl deselect", {63'd0, q_en}, 64'd0);
      idle_in;
      adv_n = 1'b0; wr_all_n = 1'b0; wdata = 36'h0_BAD0_0BAD;
      tick;
      chk("R4 no access after deselect", {63'd0, q_en}, 64'd0);
      idle_in;
      rd_proc(6'd16, "R4 word 16 unchanged");
      rd_proc(6'd17, "R4 word 17 unchanged");
      ce_hi = 1'b0; ads_proc_n = 1'b0; addr = 6'd16;
      tick;
      chk("R4 proc strobe deselect", {63'd0, q_en}, 64'd0);
      idle_in;
   endtask

   task automatic t_oe;
      idle_in;
      ads_proc_n = 1'b0; addr = 6'd16;
      tick;
      idle_in;
      oe_n = 1'b1;
      #1;
      chk("R12 oe async off", {63'd0, q_en}, 64'd0);
      chk("R12 q zero when off", {28'd0, q}, 64'd0);
      oe_n = 1'b0;
      #1;
      chk("R12 oe async on", {63'd0, q_en}, 64'd1);
      chk("R12 data back", {28'd0, q}, {28'd0, mdl[16]});
      @(negedge clk);
   endtask

   task automatic t_sleep;
      idle_in;
      ads_proc_n = 1'b0; addr = 6'd19;
      tick;
      idle_in;
      sleep = 1'b1;
      #1;
      chk("R13 sleep immediate off", {63'd0, q_en}, 64'd0);
      @(negedge clk);
      ads_ctrl_n = 1'b0; addr = 6'd19; wr_all_n = 1'b0; wdata = 36'h0_0BAD_BAD0;
      tick;
      chk("R13 no access in sleep", {63'd0, q_en}, 64'd0);
      idle_in;
      adv_n = 1'b0;
      tick;
      chk("R13 strobe needed after sleep", {63'd0, q_en}, 64'd0);
      idle_in;
      rd_proc(6'd19, "R13 no write in sleep");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle_in;
      seq_ilv = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_global_write;
      t_byte_write;
      t_linear;
      t_interleave;
      t_burst_write;
      t_priority;
      t_enables;
      t_oe;
      t_sleep;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule